// File: doc/BRIEF.md
# Holdover Frequency History Averager

This block sits beside a clock-recovery loop and remembers what the loop was doing. While the loop is locked, every sample strobe carries a signed frequency-offset word, and the block writes it into a circular history. The history holds the newest 120 seconds of samples. Time is counted in strobes: `TPS` strobes make one second, so the default of 25 gives a 3000-entry history.

When the selected input fails and no alternate input is available, the block enters holdover. It then works out a holdover frequency. It skips a selectable number of the newest samples, because those may already be corrupt. It then averages a selectable window of the samples just before them. The sum is built one sample at a time in a wide accumulator and divided once at the end. A done flag marks a valid result. An error flag marks the case where the history holds nothing past the skipped region.

Recording stops during holdover. It starts again when lock returns, and the older history is kept.

Top module: `hold_avg`

## Requirements
- R1: A strobe is written to the history only when `locked` is 1 and the block is not in holdover. The history keeps the newest 120*TPS samples (3000 by default). Older samples are overwritten, and the stored count saturates at that depth.
- R2: `win_sel` picks the window length: 0 = 1 s, 1 = 10 s, 2 = 30 s, 3 = 60 s. A length in seconds becomes ceil(ms*TPS/1000) samples, with a minimum of 1. By default that is 25, 250, 750 and 1500 samples.
- R3: `dly_sel` picks how many of the newest samples are skipped: 0 = 30 ms, 1 = 60 ms, 2 = 1 s, 3 = 10 s, 4 = 30 s, 5 = 60 s. Codes 6 and 7 act as 60 s. The same conversion gives 1, 2, 25, 250, 750 and 1500 samples by default.
- R4: Holdover is entered on a clock edge where `sel_lost` is 1, `alt_avail` is 0 and the block is not already in holdover. With `alt_avail` = 1, the event is ignored and recording goes on.
- R5: The result is the mean of the n samples that come just before the d newest samples. The mean is truncated toward zero.
- R6: If the stored count c is greater than d but less than d + window, then n = c - d.
- R7: If c <= d, `err` is set, `done` stays 0 and `hold_word` keeps its previous value.
- R8: In the cycle after an accepted entry, `done` and `err` are both 0. Exactly one of them is then set, and it holds until the next accepted entry. The two are never 1 together, and `hold_word` is stable while `done` is held.
- R9: Holdover ends on a rising edge of `locked`. Recording then resumes on top of the retained history.
- R10: Sums of up to 1500 full-scale 32-bit samples are formed without overflow, using a 48-bit accumulator.
- R11: After reset, `done` = 0, `err` = 0, `hold_word` = 0 and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Frequency sample strobe |
| smp_word | input | 32 | Signed frequency-offset sample |
| locked | input | 1 | Loop locked to a valid input |
| sel_lost | input | 1 | Selected input has just become invalid |
| alt_avail | input | 1 | Another valid input is available |
| win_sel | input | 2 | Averaging window code |
| dly_sel | input | 3 | Skip-delay code |
| hold_word | output | 32 | Averaged holdover frequency word |
| done | output | 1 | Holdover result valid |
| err | output | 1 | History too short for any average |

## Verification
Three kinds of history are averaged:
- a short ramp of ten samples, which hits the partial-window and empty-window cases;
- a 1700-sample pseudo-random history, which tells a correct window placement from one shifted by a sample or sized wrongly;
- wrapped histories of near-full-scale positive and negative words, which expose accumulator overflow, pointer wrap and rounding toward zero.

Samples that arrive during holdover are given a value far outside the rest, so that recording them would visibly shift the next average. An entry event with an alternate input available must produce no result and must leave the following average counting the samples taken after it.

// File: rtl/hold_avg_pkg.sv
package hold_avg_pkg;

  typedef enum logic [2:0] {
    EG_IDLE,
    EG_READ,
    EG_ACC,
    EG_DIV,
    EG_FAIL
  } eng_st_e;

  // Converts a span in milliseconds to a strobe count, rounding up, minimum one.
  function automatic int ms_to_smp(input int ms, input int tps);
    int v;
    v = (ms * tps + 999) / 1000;
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/hold_avg_ring.sv
module hold_avg_ring #(
  parameter int DEPTH  = 3000,
  parameter int WORD_W = 32,
  parameter int AW     = 12,
  parameter int CW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0]     wp,
  output logic [CW-1:0]     cnt
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_n;
  logic [CW-1:0]     cnt_n;

  always_comb begin
    wp_n  = wp;
    cnt_n = cnt;
    if (wr_en) begin
      wp_n = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (cnt != CW'(DEPTH)) cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      cnt <= cnt_n;
    end
  end

  // Storage array: no reset, synchronous read.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/hold_avg_span.sv
module hold_avg_span #(
  parameter int TPS   = 25,
  parameter int DEPTH = 3000,
  parameter int AW    = 12,
  parameter int CW    = 12
) (
  input  logic [1:0]    win_sel,
  input  logic [2:0]    dly_sel,
  input  logic [AW-1:0] wp,
  input  logic [CW-1:0] cnt,
  output logic [AW-1:0] start,
  output logic [CW-1:0] len,
  output logic          short_hist
);

  localparam int WIN_SMP [4] = '{
    hold_avg_pkg::ms_to_smp(1000, TPS),  hold_avg_pkg::ms_to_smp(10000, TPS),
    hold_avg_pkg::ms_to_smp(30000, TPS), hold_avg_pkg::ms_to_smp(60000, TPS)};

  localparam int DLY_SMP [8] = '{
    hold_avg_pkg::ms_to_smp(30, TPS),    hold_avg_pkg::ms_to_smp(60, TPS),
    hold_avg_pkg::ms_to_smp(1000, TPS),  hold_avg_pkg::ms_to_smp(10000, TPS),
    hold_avg_pkg::ms_to_smp(30000, TPS), hold_avg_pkg::ms_to_smp(60000, TPS),
    hold_avg_pkg::ms_to_smp(60000, TPS), hold_avg_pkg::ms_to_smp(60000, TPS)};

  always_comb begin
    int d;
    int w;
    int avail;
    int tmp;
    d     = DLY_SMP[dly_sel];
    w     = WIN_SMP[win_sel];
    avail = int'(cnt) - d;
    if (avail <= 0) begin
      short_hist = 1'b1;
      len        = '0;
    end else begin
      short_hist = 1'b0;
      len        = CW'((avail < w) ? avail : w);
    end
    // Newest sample sits at wp-1; step back d more, wrapping once.
    tmp = int'(wp) + DEPTH - 1 - d;
    if (tmp >= DEPTH) tmp = tmp - DEPTH;
    start = AW'(tmp);
  end

endmodule

// File: rtl/hold_avg_engine.sv
module hold_avg_engine #(
  parameter int DEPTH  = 3000,
  parameter int WORD_W = 32,
  parameter int ACC_W  = 48,
  parameter int AW     = 12,
  parameter int CW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     start,
  input  logic [CW-1:0]     len,
  input  logic              short_hist,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] hold_word,
  output logic              done,
  output logic              err
);

  import hold_avg_pkg::*;

  eng_st_e                  st, st_n;
  logic [AW-1:0]            ptr, ptr_n;
  logic [CW-1:0]            left, left_n;
  logic [CW-1:0]            len_q, len_n;
  logic signed [ACC_W-1:0]  acc, acc_n;
  logic signed [ACC_W-1:0]  quo;
  logic [WORD_W-1:0]        word_n;
  logic                     done_n, err_n;

  assign rd_addr = ptr;
  assign quo     = acc / $signed({{(ACC_W - CW){1'b0}}, len_q});

  always_comb begin
    st_n   = st;
    ptr_n  = ptr;
    left_n = left;
    len_n  = len_q;
    acc_n  = acc;
    word_n = hold_word;
    done_n = done;
    err_n  = err;
    if (go) begin
      ptr_n  = start;
      left_n = len;
      len_n  = len;
      acc_n  = '0;
      done_n = 1'b0;
      err_n  = 1'b0;
      st_n   = short_hist ? EG_FAIL : EG_READ;
    end else begin
      case (st)
        EG_READ: st_n = EG_ACC;
        EG_ACC: begin
          acc_n  = acc + $signed({{(ACC_W - WORD_W){rd_data[WORD_W-1]}}, rd_data});
          ptr_n  = (ptr == '0) ? AW'(DEPTH - 1) : ptr - 1'b1;
          left_n = left - 1'b1;
          st_n   = (left == CW'(1)) ? EG_DIV : EG_READ;
        end
        EG_DIV: begin
          word_n = quo[WORD_W-1:0];
          done_n = 1'b1;
          st_n   = EG_IDLE;
        end
        EG_FAIL: begin
          err_n = 1'b1;
          st_n  = EG_IDLE;
        end
        default: st_n = EG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= EG_IDLE;
      ptr       <= '0;
      left      <= '0;
      len_q     <= '0;
      acc       <= '0;
      hold_word <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      st        <= st_n;
      ptr       <= ptr_n;
      left      <= left_n;
      len_q     <= len_n;
      acc       <= acc_n;
      hold_word <= word_n;
      done      <= done_n;
      err       <= err_n;
    end
  end

endmodule

// File: rtl/hold_avg.sv
module hold_avg #(
  parameter int TPS    = 25,
  parameter int WORD_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              locked,
  input  logic              sel_lost,
  input  logic              alt_avail,
  input  logic [1:0]        win_sel,
  input  logic [2:0]        dly_sel,
  output logic [WORD_W-1:0] hold_word,
  output logic              done,
  output logic              err
);

  localparam int DEPTH = 120 * TPS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [1:0]        rsync;
  logic              rst_q_n;
  logic              in_hold, in_hold_n;
  logic              lock_q;
  logic              accept, lock_rise, rec_en;
  logic [AW-1:0]     wp, rd_addr, start;
  logic [CW-1:0]     cnt, len;
  logic              short_hist;
  logic [WORD_W-1:0] rd_data;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  assign accept    = sel_lost && !alt_avail && !in_hold;
  assign lock_rise = locked && !lock_q;
  assign rec_en    = smp_stb && locked && !in_hold;

  always_comb begin
    in_hold_n = in_hold;
    if (accept)         in_hold_n = 1'b1;
    else if (lock_rise) in_hold_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      in_hold <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      in_hold <= in_hold_n;
      lock_q  <= locked;
    end
  end

  hold_avg_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW), .CW(CW)) ring_i (
    .clk(clk), .rst_n(rst_q_n), .wr_en(rec_en), .wr_data(smp_word),
    .rd_addr(rd_addr), .rd_data(rd_data), .wp(wp), .cnt(cnt)
  );

  hold_avg_span #(.TPS(TPS), .DEPTH(DEPTH), .AW(AW), .CW(CW)) span_i (
    .win_sel(win_sel), .dly_sel(dly_sel), .wp(wp), .cnt(cnt),
    .start(start), .len(len), .short_hist(short_hist)
  );

  hold_avg_engine #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ACC_W(ACC_W), .AW(AW), .CW(CW)) eng_i (
    .clk(clk), .rst_n(rst_q_n), .go(accept), .start(start), .len(len),
    .short_hist(short_hist), .rd_addr(rd_addr), .rd_data(rd_data),
    .hold_word(hold_word), .done(done), .err(err)
  );

endmodule

// File: rtl/hold_avg_chk.sv
module hold_avg_chk #(
  parameter int DEPTH  = 3000,
  parameter int CW     = 12,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_lost,
  input logic              alt_avail,
  input logic              in_hold,
  input logic [CW-1:0]     cnt,
  input logic [WORD_W-1:0] hold_word,
  input logic              done,
  input logic              err
);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r8_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lost && !alt_avail && !in_hold) |=> (!done && !err && in_hold));

  a_r4_alt_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lost && alt_avail && !in_hold) |=> !in_hold);

  a_r1_no_record_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |=> $stable(cnt));

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r7_err_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $stable(hold_word));

  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(hold_word));

endmodule

bind hold_avg hold_avg_chk #(.DEPTH(DEPTH), .CW(CW), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_q_n), .sel_lost(sel_lost), .alt_avail(alt_avail),
  .in_hold(in_hold), .cnt(cnt), .hold_word(hold_word), .done(done), .err(err)
);

// File: tb/hold_avg_tb_top.sv
module hold_avg_tb_top;

  localparam int DEPTH = 3000;
  localparam int WIN [4] = '{25, 250, 750, 1500};
  localparam int DLY [8] = '{1, 2, 25, 250, 750, 1500, 1500, 1500};

  typedef struct {
    logic       e_err;
    logic [31:0] e_word;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_stb;
  logic [31:0] smp_word;
  logic        locked, sel_lost, alt_avail;
  logic [1:0]  win_sel;
  logic [2:0]  dly_sel;
  logic [31:0] hold_word;
  logic        done, err;

  int   n_vec = 0;
  int   n_bad = 0;
  int   hist[$];
  exp_t sb[$];
  bit   hold_m = 1'b0;
  logic [31:0] last_word = '0;
  logic prev_done = 1'b0, prev_err = 1'b0;

  always #5 clk = ~clk;

  hold_avg dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_word(smp_word),
    .locked(locked), .sel_lost(sel_lost), .alt_avail(alt_avail),
    .win_sel(win_sel), .dly_sel(dly_sel), .hold_word(hold_word),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    smp_stb  = 1'b1;
    smp_word = v;
    if (locked && !hold_m) hist.push_back(v);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // Driver: fires an entry event and queues the expected result.
  task automatic enter(input int ws, input int ds, input string tag);
    exp_t e;
    int c, d, n;
    longint sum;
    @(negedge clk);
    sel_lost  = 1'b1;
    alt_avail = 1'b0;
    locked    = 1'b0;
    win_sel   = 2'(ws);
    dly_sel   = 3'(ds);
    c = (hist.size() < DEPTH) ? hist.size() : DEPTH;
    d = DLY[ds];
    e.tag = tag;
    if (c <= d) begin
      e.e_err  = 1'b1;
      e.e_word = last_word;
    end else begin
      n = c - d;
      if (n > WIN[ws]) n = WIN[ws];
      sum = 0;
      for (int k = 0; k < n; k++) sum += longint'(hist[hist.size() - 1 - d - k]);
      e.e_err   = 1'b0;
      e.e_word  = 32'(sum / longint'(n));
      last_word = e.e_word;
    end
    sb.push_back(e);
    hold_m = 1'b1;
    @(negedge clk);
    sel_lost = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic relock();
    @(negedge clk);
    locked = 1'b1;
    hold_m = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per rising result flag.
  always @(negedge clk) begin
    if (rst_n) begin
      if ((done && !prev_done) || (err && !prev_err)) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R4 unexpected result", longint'(hold_word), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(err == e.e_err && done == !e.e_err, {e.tag, " flag"}, longint'(err), longint'(e.e_err));
          chk(hold_word == e.e_word, {e.tag, " word"},
              longint'($signed(hold_word)), longint'($signed(e.e_word)));
        end
      end
      prev_done <= done;
      prev_err  <= err;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_stb = 1'b0; smp_word = '0; locked = 1'b0;
    sel_lost = 1'b0; alt_avail = 1'b0; win_sel = '0; dly_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 done after reset", longint'(done), 0);
    chk(err == 1'b0, "R11 err after reset", longint'(err), 0);
    chk(hold_word == '0, "R11 word after reset", longint'(hold_word), 0);

    enter(0, 0, "R7 R11 empty history");
    relock();
    for (int i = 0; i < 10; i++) push(i * 100 + 7);
    enter(0, 0, "R6 partial window");
    relock();
    enter(0, 5, "R7 delay beyond history");
    relock();
    for (int i = 0; i < 1700; i++) push((i * 7919) % 20001 - 10000);
    enter(1, 2, "R2 R3 R5 10s window 1s skip");
    relock();
    enter(0, 1, "R3 60ms skip");
    relock();

    @(negedge clk);
    sel_lost = 1'b1; alt_avail = 1'b1;
    @(negedge clk);
    sel_lost = 1'b0; alt_avail = 1'b0;
    repeat (10) @(negedge clk);
    chk(done == 1'b1 && err == 1'b0, "R4 entry ignored with alternate", longint'(done), 1);
    for (int i = 0; i < 5; i++) push(-40000 - i * 3);
    enter(0, 0, "R4 recording continued");

    for (int i = 0; i < 50; i++) push(1000000);
    relock();
    for (int i = 0; i < 30; i++) push(i * 11 - 150);
    enter(0, 0, "R1 R9 holdover samples ignored");
    relock();
    enter(3, 3, "R9 older history kept");
    relock();

    for (int i = 0; i < 3100; i++) push(32'h7FFF_FFF0 - (i % 3));
    enter(3, 5, "R1 R10 full depth positive");
    relock();
    for (int i = 0; i < 3100; i++) push(-2147483000 + (i % 5));
    enter(3, 4, "R10 R5 negative truncation");
    relock();
    enter(0, 7, "R3 code 7 as 60s");
    relock();

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule